// File: doc/BRIEF.md
# Page Translation Buffer with Table Walk

This block turns a 31-bit virtual byte address into a 27-bit physical byte address for 4 KB pages. The upper 19 bits of the virtual address form the virtual page number, and the low 12 bits form the page offset. A small, fully associative store holds recent page mappings and checks all of them at once. On a hit the translated address comes back in the same cycle as the request.

On a miss the block reads one page table entry through a read port, using the virtual page number as the index. If the returned entry is marked present, the block installs the entry and answers with the translated address. If the entry is marked absent, the block answers with a fault. A flush input empties the store in one cycle.

A small state machine sequences a miss. It has three states:
- `ST_IDLE` accepts requests and answers hits directly. A miss moves it to `ST_WAIT` through the `start walk` transition.
- `ST_WAIT` waits for the table read to return. The return moves it to `ST_RESP` through the `table return` transition.
- `ST_RESP` presents the result for one cycle. It then moves back to `ST_IDLE` through the `respond` transition.

Top module: `tlb_walker`

## Requirements
- R1: A request accepted while a valid stored entry holds its virtual page number (bits 30:12) is answered in the same cycle. The answer has `rsp_valid` high, `rsp_fault` low, and `rsp_paddr` equal to the stored 15-bit physical page number above the unchanged bits 11:0. For example, page 0x2 mapped to 0x7FFF turns 0x247C into 0x7FFF47C, and page 5 mapped to 1 turns 0x5F20 into 0x1F20.
- R2: After reset, and for any page not held in a valid entry, an accepted request gets no same-cycle answer (`rsp_valid` low).
- R3: A missing request raises `pt_req` for exactly its acceptance cycle, with `pt_idx` equal to the virtual page number.
- R4: A page table entry (bit 15 = present, bits 14:0 = physical page number) returned on `pt_ack` with bit 15 set produces the answer in the next cycle. That cycle is L+1 cycles after the request, where L is the read latency. The answer carries `rsp_fault` low and the translated address. The mapping is installed, so a later request to the same page hits.
- R5: A returned entry with bit 15 clear produces an answer with `rsp_fault` high and `rsp_paddr` zero. Nothing is installed, so the same page misses again.
- R6: `req_ready` is high in idle. It is low from the cycle after a miss is accepted through the cycle of its answer.
- R7: An install goes to the lowest-numbered invalid entry. When every entry is valid, it replaces the entry named by a round-robin pointer, which starts at entry 0 and advances only on such a replacement.
- R8: A cycle with `flush` high invalidates every entry, so the next accepted request misses.
- R9: Flush has priority over install. A table return with flush high in the same cycle still answers, but leaves nothing installed. A hit with flush high in the same cycle is still answered from the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all stored mappings |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 31 | Virtual byte address |
| rsp_valid | output | 1 | Answer present this cycle |
| rsp_paddr | output | 27 | Physical byte address (zero on fault) |
| rsp_fault | output | 1 | Page not resident |
| pt_req | output | 1 | Page table read strobe |
| pt_idx | output | 19 | Page table index (virtual page number) |
| pt_ack | input | 1 | Page table data returned |
| pt_pte | input | 16 | Returned entry: bit 15 present, bits 14:0 page |

## Verification
Two functions can land in the same cycle: a flush and an install (or a flush and a hit). The bench provokes both. It raises `flush` in exactly the cycle where the table data returns, and separately in the cycle of a hitting request. It then judges the outcome at the ports. The answer must still appear with the correct address. A following request to that page must start a new table read, which shows that flush won over the install. A reference model of the stored mappings, including the victim order, predicts hit or miss, latency and result for every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 31;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 15;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int PTE_W  = PPN_W + 1;

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } map_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } walk_state_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    map_entry_t            ent [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match;
    logic [IDX_W-1:0]      rr_ptr;
    logic [IDX_W-1:0]      victim;
    logic                  any_free;

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            assign match[g] = ent[g].v && (ent[g].vpn == lk_vpn);
        end
    endgenerate

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match[i]) lk_ppn = lk_ppn | ent[i].ppn;
        end
    end
    assign lk_hit = |match;

    always_comb begin
        any_free = 1'b0;
        victim   = rr_ptr;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!ent[i].v) begin
                any_free = 1'b1;
                victim   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent[i] <= '0;
            if (!rst_n) rr_ptr <= '0;
        end else if (ins_en) begin
            ent[victim] <= '{v: 1'b1, vpn: ins_vpn, ppn: ins_ppn};
            if (!any_free) begin
                rr_ptr <= (rr_ptr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        lut_hit,
    input  logic        pt_ack,
    output walk_state_t state,
    output logic        req_ready,
    output logic        walk_start,
    output logic        walk_done,
    output logic        resp_slot
);
    walk_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid && !lut_hit) nxt = ST_WAIT;
            ST_WAIT: if (pt_ack) nxt = ST_RESP;
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        req_ready  = 1'b0;
        walk_start = 1'b0;
        walk_done  = 1'b0;
        resp_slot  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready  = 1'b1;
                walk_start = req_valid && !lut_hit;
            end
            ST_WAIT: walk_done = pt_ack;
            ST_RESP: resp_slot = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             pt_req,
    output logic [VPN_W-1:0] pt_idx,
    input  logic             pt_ack,
    input  logic [PTE_W-1:0] pt_pte
);
    walk_state_t      state;
    logic             hit;
    logic [PPN_W-1:0] hit_ppn;
    logic             walk_start, walk_done, resp_slot;
    logic [VPN_W-1:0] cap_vpn;
    logic [OFF_W-1:0] cap_off;
    logic [PPN_W-1:0] res_ppn;
    logic             res_fault;
    logic             pte_present;

    assign pte_present = pt_pte[PTE_W-1];

    tlb_cam #(.NUM_ENTRIES(NUM_ENTRIES)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_vpn  (req_vaddr[VA_W-1:OFF_W]),
        .lk_hit  (hit),
        .lk_ppn  (hit_ppn),
        .ins_en  (walk_done && pte_present),
        .ins_vpn (cap_vpn),
        .ins_ppn (pt_pte[PPN_W-1:0])
    );

    tlb_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lut_hit    (hit),
        .pt_ack     (pt_ack),
        .state      (state),
        .req_ready  (req_ready),
        .walk_start (walk_start),
        .walk_done  (walk_done),
        .resp_slot  (resp_slot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vpn   <= '0;
            cap_off   <= '0;
            res_ppn   <= '0;
            res_fault <= 1'b0;
        end else begin
            if (walk_start) begin
                cap_vpn <= req_vaddr[VA_W-1:OFF_W];
                cap_off <= req_vaddr[OFF_W-1:0];
            end
            if (walk_done) begin
                res_ppn   <= pte_present ? pt_pte[PPN_W-1:0] : '0;
                res_fault <= !pte_present;
            end
        end
    end

    assign pt_req = walk_start;
    assign pt_idx = req_vaddr[VA_W-1:OFF_W];

    always_comb begin
        rsp_valid = 1'b0;
        rsp_paddr = '0;
        rsp_fault = 1'b0;
        if (resp_slot) begin
            rsp_valid = 1'b1;
            rsp_fault = res_fault;
            rsp_paddr = res_fault ? '0 : {res_ppn, cap_off};
        end else if (state == ST_IDLE && req_valid && hit) begin
            rsp_valid = 1'b1;
            rsp_paddr = {hit_ppn, req_vaddr[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic             pt_req,
    input logic [VPN_W-1:0] pt_idx,
    input logic             pt_ack
);
    AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rsp_valid) |-> (rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0] && !rsp_fault)); // R1
    AST_MISS_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |-> !rsp_valid); // R2
    AST_WALK_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |-> (req_valid && req_ready && pt_idx == req_vaddr[VA_W-1:OFF_W])); // R3
    AST_WALK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |=> !pt_req); // R3
    AST_RETURN_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_ack && !req_ready) |=> (rsp_valid && !req_ready)); // R4
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R5
    AST_BUSY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req |=> !req_ready); // R6
    AST_READY_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !req_ready) |=> req_ready); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && req_valid && req_ready) |-> pt_req); // R8
endmodule

bind tlb_walker tlb_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .pt_req    (pt_req),
    .pt_idx    (pt_idx),
    .pt_ack    (pt_ack)
);

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [30:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [26:0] rsp_paddr;
    logic        rsp_fault;
    logic        pt_req;
    logic [18:0] pt_idx;
    logic        pt_ack;
    logic [15:0] pt_pte;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    int          mem_cnt = 0;
    int          mem_lat = 1;
    logic [18:0] mem_idx = '0;

    bit          mv   [N];
    logic [18:0] mvpn [N];
    logic [14:0] mppn [N];
    int          mptr = 0;

    always #5 clk = ~clk;

    tlb_walker #(.NUM_ENTRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .pt_req(pt_req), .pt_idx(pt_idx), .pt_ack(pt_ack), .pt_pte(pt_pte)
    );

    function automatic logic [15:0] pte_of(input logic [18:0] vpn);
        if (vpn == 19'h2)               return {1'b1, 15'h7FFF};
        if (vpn == 19'h5)               return {1'b1, 15'h0001};
        if (vpn == 19'h7 || vpn[3:0] == 4'hF) return 16'h0000;
        return {1'b1, vpn[14:0] ^ 15'h2A5};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) mem_cnt <= 0;
        else if (pt_req) begin
            mem_cnt <= mem_lat;
            mem_idx <= pt_idx;
        end else if (mem_cnt > 0) mem_cnt <= mem_cnt - 1;
    end
    assign pt_ack = (mem_cnt == 1);
    assign pt_pte = pte_of(mem_idx);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, actual=%0d expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [18:0] vpn);
        for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
    endtask

    task automatic m_install(input logic [18:0] vpn, input logic [14:0] ppn);
        int slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
        if (slot < 0) begin
            slot = mptr;
            mptr = (mptr + 1) % N;
        end
        mv[slot] = 1'b1; mvpn[slot] = vpn; mppn[slot] = ppn;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); #1;
            chk(req_ready == 1'b1, "R6", "idle ready", 32'(req_ready), 32'd1);
            chk(rsp_valid == 1'b0 && pt_req == 1'b0, "R2", "idle quiet",
                {30'd0, rsp_valid, pt_req}, 32'd0);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1; #1;
        chk(rsp_valid == 1'b0, "R8", "flush quiet", 32'(rsp_valid), 32'd0);
        @(posedge clk); m_clear();
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic xlate(input logic [30:0] va, input int lat, input bit fl_now, input bit fl_ret);
        logic [18:0] vpn;
        logic [15:0] pte;
        int          idx;
        int          n;
        vpn = va[30:12];
        @(negedge clk);
        mem_lat = lat; req_valid = 1'b1; req_vaddr = va; flush = fl_now; #1;
        idx = m_find(vpn);
        chk(req_ready == 1'b1, "R6", "ready at request", 32'(req_ready), 32'd1);
        if (idx >= 0) begin
            chk(rsp_valid == 1'b1, "R1", "hit answer", 32'(rsp_valid), 32'd1);
            chk(rsp_paddr == {mppn[idx], va[11:0]} && !rsp_fault, "R1", "hit address",
                32'(rsp_paddr), 32'({mppn[idx], va[11:0]}));
            chk(pt_req == 1'b0, "R2", "no walk on hit", 32'(pt_req), 32'd0);
            if (fl_now) chk(rsp_valid == 1'b1, "R9", "hit during flush", 32'(rsp_valid), 32'd1);
            @(posedge clk);
            if (fl_now) m_clear();
            @(negedge clk); req_valid = 1'b0; flush = 1'b0;
        end else begin
            chk(rsp_valid == 1'b0, "R2", "miss no answer", 32'(rsp_valid), 32'd0);
            chk(pt_req == 1'b1, "R3", "walk strobe", 32'(pt_req), 32'd1);
            chk(pt_idx == vpn, "R3", "walk index", 32'(pt_idx), 32'(vpn));
            @(negedge clk); req_valid = 1'b0; req_vaddr = 31'h7FFF_FFFF;
            n = 1;
            while (n < 1000) begin
                flush = (fl_ret && n == lat);
                #1;
                if (rsp_valid) break;
                chk(req_ready == 1'b0, "R6", "busy during walk", 32'(req_ready), 32'd0);
                chk(pt_req == 1'b0, "R3", "single strobe", 32'(pt_req), 32'd0);
                @(negedge clk);
                n++;
            end
            chk(n == lat + 1, "R4", "answer latency", 32'(n), 32'(lat + 1));
            chk(req_ready == 1'b0, "R6", "busy at answer", 32'(req_ready), 32'd0);
            pte = pte_of(vpn);
            if (pte[15]) begin
                chk(rsp_fault == 1'b0, "R4", "no fault", 32'(rsp_fault), 32'd0);
                chk(rsp_paddr == {pte[14:0], va[11:0]}, "R4", "walk address",
                    32'(rsp_paddr), 32'({pte[14:0], va[11:0]}));
                if (fl_ret) m_clear(); else m_install(vpn, pte[14:0]);
            end else begin
                chk(rsp_fault == 1'b1, "R5", "fault flag", 32'(rsp_fault), 32'd1);
                chk(rsp_paddr == 27'd0, "R5", "fault address", 32'(rsp_paddr), 32'd0);
                if (fl_ret) m_clear();
            end
            @(negedge clk); flush = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && pt_req == 1'b0, "R6", "reset state",
            {29'd0, req_ready, rsp_valid, pt_req}, 32'h4);
        rst_n = 1'b1;
        idle(2);
        // R1 R4: known example mappings, first a walk then a hit
        xlate(31'h247C, 2, 0, 0);
        xlate(31'h2000, 1, 0, 0);
        xlate(31'h5F20, 3, 0, 0);
        xlate(31'h5F20, 1, 0, 0);
        xlate(31'h247C, 1, 0, 0);
        // R5: absent page faults twice, never installed
        xlate(31'h73E0, 2, 0, 0);
        xlate(31'h73E0, 4, 0, 0);
        idle(1);
        // R8: flush empties
        do_flush();
        xlate(31'h247C, 1, 0, 0);
        // R7: victim order
        do_flush();
        xlate(31'h10_123, 2, 0, 0);
        xlate(31'h11_456, 2, 0, 0);
        xlate(31'h10_789, 1, 0, 0);
        xlate(31'h12_000, 2, 0, 0);
        xlate(31'h11_001, 1, 0, 0);
        xlate(31'h10_002, 3, 0, 0);
        xlate(31'h12_003, 1, 0, 0);
        xlate(31'h13_004, 2, 0, 0);
        xlate(31'h10_005, 1, 0, 0);
        xlate(31'h12_006, 1, 0, 0);
        // R9: flush in the return cycle, then flush with a hit
        do_flush();
        xlate(31'h20_0AB, 3, 0, 1);
        xlate(31'h20_0AC, 2, 0, 0);
        xlate(31'h20_0AD, 1, 1, 0);
        xlate(31'h20_0AE, 1, 0, 0);
        xlate(31'h1F_000, 1, 0, 1);
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule